// File: doc/BRIEF.md
# Double-Buffered Frequency Word Register Bank

This block is the host-facing register file of a numerically controlled oscillator. A host with a byte-wide, write-only parallel bus loads two 48-bit frequency words, a center word and an offset word, one byte per write. Every byte lands first in a shadow register. The oscillator reads from a second, live set of registers instead.

A separate commit input moves the whole shadow set into the live set in a single clock cycle. The host can therefore rewrite any number of bytes across both words. The oscillator keeps running on the old pair of words until the commit. After the commit it runs on the complete new pair, and it never sees a word that is only partly written.

The write strobe and the commit input arrive from outside the clock domain. Each one passes through a synchronizer and an edge detector before it acts.

Top module: `freq_regbank_top`

## Requirements
- R1: While `rst_n` is low, all shadow and live registers clear to zero, so both output words read zero.
- R2: A byte is stored only on a rising edge of `host_wr` seen while `host_wen` is high. A strobe edge with `host_wen` low changes no register.
- R3: Addresses 0 through 5 select center word bytes with the least significant byte first. Address 0 is bits 7:0 and address 5 is bits 47:40.
- R4: Addresses 6 through 11 select offset word bytes. Address 6 is bits 7:0 and address 11 is bits 47:40.
- R5: A write to address 12, 13, 14 or 15 changes no register.
- R6: Writes do not reach `center_word` or `offset_word` until a commit takes place.
- R7: Each rising edge of `commit_in` copies both shadow words into the live words in one clock cycle. Holding `commit_in` high causes no further copies.
- R8: When a byte write and a commit act in the same clock cycle, the live word receives the newly written byte.
- R9: Holding `host_wr` high stores one byte only. Changing `host_data` while the strobe stays high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_data | input | 8 | Write data byte |
| host_addr | input | 4 | Byte slot address |
| host_wr | input | 1 | Write strobe; a rising edge requests a write |
| host_wen | input | 1 | Write enable; must be high for a write to take effect |
| commit_in | input | 1 | Commit request; a rising edge copies shadow into live |
| center_word | output | 48 | Live center frequency word |
| offset_word | output | 48 | Live offset frequency word |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 4-bit address, six bytes per word and two synchronizer stages. These values leave four unused addresses above the twelve byte slots, so the ignored-address rule can be checked. The six-byte words let every byte position of both words be loaded and checked after a single commit. The two-stage synchronizers give the strobe and the commit the same latency. This makes it possible to raise both inputs on the same edge and have them act in the same cycle, which is how the write-during-commit case is reached.

// File: rtl/freq_regbank_pkg.sv
package freq_regbank_pkg;
  localparam int unsigned BYTE_W_DEF     = 8;
  localparam int unsigned ADDR_W_DEF     = 4;
  localparam int unsigned WORD_BYTES_DEF = 6;
  localparam int unsigned SYNC_DEF       = 2;
endpackage

// File: rtl/frb_rst_sync.sv
module frb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/frb_edge_sync.sv
module frb_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_pulse = sync_q[STAGES-1] & ~prev_q;

  // one action per rising edge (R7, R9)
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/frb_shadow_bank.sv
module frb_shadow_bank #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned WORD_BYTES = 6
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     wr_pulse,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic [2*WORD_BYTES*BYTE_W-1:0] shadow_q,
  output logic [2*WORD_BYTES*BYTE_W-1:0] shadow_d
);
  localparam int unsigned SLOTS   = 2 * WORD_BYTES;
  localparam int unsigned TOTAL_W = SLOTS * BYTE_W;

  logic wr_go;
  logic [SLOTS-1:0] slot_hit;

  assign wr_go = wr_pulse & wr_en;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_hit[g] = wr_go && (wr_addr == ADDR_W'(g));
    always_comb begin
      shadow_d[g*BYTE_W +: BYTE_W] = slot_hit[g] ? wr_data
                                                 : shadow_q[g*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else         shadow_q <= shadow_d;
  end

  // gated or absent write leaves shadow untouched
  assert_no_write_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_pulse && wr_en) |=> $stable(shadow_q));
  // addresses past the last slot are dropped
  assert_high_addr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_pulse && wr_en && (int'(wr_addr) >= SLOTS)) |=> $stable(shadow_q));
  // at most one slot per write
  assert_one_slot_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(slot_hit));

  logic unused_w;
  assign unused_w = ^TOTAL_W;
endmodule

// File: rtl/frb_live_bank.sv
module frb_live_bank #(
  parameter int unsigned TOTAL_W = 96
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               commit_pulse,
  input  logic [TOTAL_W-1:0] shadow_d,
  output logic [TOTAL_W-1:0] live_q
);
  logic [TOTAL_W-1:0] live_d;

  always_comb live_d = commit_pulse ? shadow_d : live_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) live_q <= '0;
    else         live_q <= live_d;
  end

  // live words hold between commits
  assert_hold_without_commit_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !commit_pulse |=> $stable(live_q));
  // commit takes the shadow value including a same-cycle write (R7, R8)
  assert_commit_copies_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    commit_pulse |=> (live_q == $past(shadow_d)));
endmodule

// File: rtl/freq_regbank_top.sv
module freq_regbank_top
  import freq_regbank_pkg::*;
#(
  parameter int unsigned BYTE_W      = BYTE_W_DEF,
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned WORD_BYTES  = WORD_BYTES_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BYTE_W-1:0]            host_data,
  input  logic [ADDR_W-1:0]            host_addr,
  input  logic                         host_wr,
  input  logic                         host_wen,
  input  logic                         commit_in,
  output logic [WORD_BYTES*BYTE_W-1:0] center_word,
  output logic [WORD_BYTES*BYTE_W-1:0] offset_word
);
  localparam int unsigned WORD_W  = WORD_BYTES * BYTE_W;
  localparam int unsigned TOTAL_W = 2 * WORD_W;

  logic               rst_ni;
  logic               wr_pulse;
  logic               commit_pulse;
  logic [TOTAL_W-1:0] shadow_q;
  logic [TOTAL_W-1:0] shadow_d;
  logic [TOTAL_W-1:0] live_q;

  frb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  frb_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .async_in   (host_wr),
    .rise_pulse (wr_pulse)
  );

  frb_edge_sync #(.STAGES(SYNC_STAGES)) u_commit_edge (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .async_in   (commit_in),
    .rise_pulse (commit_pulse)
  );

  frb_shadow_bank #(
    .BYTE_W     (BYTE_W),
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_shadow (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wr_pulse (wr_pulse),
    .wr_en    (host_wen),
    .wr_addr  (host_addr),
    .wr_data  (host_data),
    .shadow_q (shadow_q),
    .shadow_d (shadow_d)
  );

  frb_live_bank #(.TOTAL_W(TOTAL_W)) u_live (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .commit_pulse (commit_pulse),
    .shadow_d     (shadow_d),
    .live_q       (live_q)
  );

  assign center_word = live_q[WORD_W-1:0];
  assign offset_word = live_q[TOTAL_W-1:WORD_W];

  // reset clears outputs
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_ni |=> (center_word == '0 && offset_word == '0));

  logic unused_shadow;
  assign unused_shadow = ^shadow_q;
endmodule

// File: tb/tb_freq_regbank_top.sv
module tb_freq_regbank_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  host_data;
  logic [3:0]  host_addr;
  logic        host_wr;
  logic        host_wen;
  logic        commit_in;
  logic [47:0] center_word;
  logic [47:0] offset_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [47:0] m_center;
  logic [47:0] m_offset;

  always #5 clk = ~clk;

  freq_regbank_top dut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_addr(host_addr),
    .host_wr(host_wr), .host_wen(host_wen), .commit_in(commit_in),
    .center_word(center_word), .offset_word(offset_word)
  );

  // {addr, data}
  localparam logic [11:0] WR_TABLE [14] = '{
    {4'd0, 8'h11}, {4'd1, 8'h22}, {4'd2, 8'h33}, {4'd3, 8'h44},
    {4'd4, 8'h55}, {4'd5, 8'h66}, {4'd12, 8'hAA}, {4'd6, 8'h81},
    {4'd7, 8'h92}, {4'd8, 8'hA3}, {4'd9, 8'hB4}, {4'd10, 8'hC5},
    {4'd11, 8'hD6}, {4'd15, 8'h5E}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    if (a < 4'd6)       m_center[int'(a)*8 +: 8] = d;
    else if (a < 4'd12) m_offset[(int'(a)-6)*8 +: 8] = d;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    host_addr = a; host_data = d; host_wen = en; host_wr = 1'b1;
    repeat (4) @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic commit();
    @(negedge clk);
    commit_in = 1'b1;
    repeat (4) @(negedge clk);
    commit_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; host_data = '0; host_addr = '0; host_wr = 1'b0;
    host_wen = 1'b0; commit_in = 1'b0;
    m_center = '0; m_offset = '0;
    repeat (3) @(negedge clk);
    chk("R1 center in reset", center_word, 48'h0);
    chk("R1 offset in reset", offset_word, 48'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R3, R4, R5
    for (int i = 0; i < 14; i++) begin
      host_write(WR_TABLE[i][11:8], WR_TABLE[i][7:0], 1'b1);
      model_write(WR_TABLE[i][11:8], WR_TABLE[i][7:0]);
    end
    chk("R6 center before commit", center_word, 48'h0);
    chk("R6 offset before commit", offset_word, 48'h0);
    commit();
    chk("R3 center byte order", center_word, m_center);
    chk("R4 offset byte order", offset_word, m_offset);
    chk("R3 literal center", center_word, 48'h665544332211);

    // R2: enable low
    host_write(4'd2, 8'hEE, 1'b0);
    commit();
    chk("R2 wen low center", center_word, m_center);

    // R5: high addresses
    host_write(4'd13, 8'h77, 1'b1);
    host_write(4'd14, 8'h78, 1'b1);
    commit();
    chk("R5 high addr center", center_word, m_center);
    chk("R5 high addr offset", offset_word, m_offset);

    // R9: strobe held, data changes
    @(negedge clk);
    host_addr = 4'd9; host_data = 8'h3C; host_wen = 1'b1; host_wr = 1'b1;
    repeat (4) @(negedge clk);
    host_data = 8'hC3;
    repeat (4) @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    model_write(4'd9, 8'h3C);
    commit();
    chk("R9 single capture", offset_word, m_offset);

    // R7: commit held high, later write not copied
    @(negedge clk);
    commit_in = 1'b1;
    repeat (4) @(negedge clk);
    host_write(4'd1, 8'h99, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 held commit no copy", center_word, m_center);
    commit_in = 1'b0;
    repeat (3) @(negedge clk);
    model_write(4'd1, 8'h99);
    commit();
    chk("R7 next edge copies", center_word, m_center);

    // R8: write and commit in same cycle
    @(negedge clk);
    host_addr = 4'd11; host_data = 8'h5A; host_wen = 1'b1;
    host_wr = 1'b1; commit_in = 1'b1;
    repeat (4) @(negedge clk);
    host_wr = 1'b0; commit_in = 1'b0;
    repeat (3) @(negedge clk);
    model_write(4'd11, 8'h5A);
    chk("R8 same-cycle offset", offset_word, m_offset);
    chk("R8 same-cycle center", center_word, m_center);

    // R1: reset mid-operation clears shadow too
    host_write(4'd0, 8'hF0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 center after reset", center_word, 48'h0);
    chk("R1 offset after reset", offset_word, 48'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    commit();
    chk("R1 shadow cleared", center_word, 48'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule